// File: doc/BRIEF.md
# GPIO Controller with Flash-Strobe and Serial-Sensor Taps

This block is a register-mapped general-purpose I/O controller with two ports, A and D. Each port has three words: an output latch, an output-enable mask and an input view. A 32-bit register bus with separate read and write strobes reaches all the words. Every word that is not one of the two input views is plain read/write storage. The bus window is 23 words long.

A few output-latch bits also drive nearby peripherals. Three bits of the port A latch drive the control strobes of a NAND flash: address-latch, command-latch and chip-enable. Port D carries a bit-banged serial link to a temperature sensor. When a write flips the clock bit of the port D latch, the block emits a one-cycle edge event. The event carries the new clock level and the data bit from the same write. In the other direction, each input view reports the driven bits of its port, meaning the output latch masked by the enable. The view then adds one peripheral status bit: flash ready on port A, sensor serial output on port D.

The interface carries no back-pressure. A write completes in the cycle of its strobe. A read returns its data exactly one cycle after its strobe, marked by a valid flag. No ready signal exists, so the bus side must accept read data in that cycle.

Top module: `gpio_tap_ctrl`

## Requirements
- R1: After reset, every stored word is zero. The flash strobes, the edge event, the read-valid flag and the read data are all zero.
- R2: Word index is the byte address shifted right by two. A full-width write to a storage word (any index below 23 other than 0x01 and 0x11) stores the data. A read strobe returns the stored value on bus_rdata one cycle later, with bus_rvalid high in that cycle only.
- R3: A read of word 0x01 returns (word 0x00 AND word 0x02), with bit 7 replaced by OR-ing in flash_rdy as sampled at the read strobe.
- R4: A read of word 0x11 returns (word 0x10 AND word 0x12), with sensor_sdo OR-ed into bit 4 as sampled at the read strobe.
- R5: flash_ale, flash_cle and flash_ce follow bits 6, 5 and 4 of word 0x00. They change in the cycle after a write to that word and at no other time.
- R6: A write to word 0x10 whose bit 1 differs from the stored bit 1 raises sclk_evt for exactly one cycle after the write. In that cycle sclk_level equals the written bit 1 and sclk_sdi equals the written bit 4. A write that leaves bit 1 unchanged raises no event.
- R7: An access whose byte enable is not 4'hF is ignored. A write changes nothing, and a read still gives bus_rvalid but returns zero.
- R8: An access at word index 23 or above is ignored. A write changes nothing and a read returns zero.
- R9: Writes to the input-view words 0x01 and 0x11 have no effect on any readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 7 | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| flash_rdy | input | 1 | Flash ready status |
| sensor_sdo | input | 1 | Sensor serial output |
| flash_ale | output | 1 | Flash address-latch strobe |
| flash_cle | output | 1 | Flash command-latch strobe |
| flash_ce | output | 1 | Flash chip-enable |
| sclk_evt | output | 1 | One-cycle sensor clock edge event |
| sclk_level | output | 1 | New sensor clock level |
| sclk_sdi | output | 1 | Serial data bit toward the sensor |

## Verification
The hardest case to reach from the ports is the absence of an edge event. That happens when a port D write changes other bits, including the data bit, but keeps the clock bit at its stored level. The stimulus steps through a rising write, a write that changes only the data bit, and then a falling write. After each step it looks for the pulse one cycle later. Input-view reads are also run with the enable mask only partly set and with the peripheral status toggled. This separates the masked output bits from the OR-ed status bit.

// File: rtl/gpio_tap_pkg.sv
package gpio_tap_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 23;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int ADDR_W    = IDX_W + 2;
  localparam int BE_W      = DATA_W / 8;

  localparam logic [IDX_W-1:0] IDX_A_OUT = 5'h00;
  localparam logic [IDX_W-1:0] IDX_A_IN  = 5'h01;
  localparam logic [IDX_W-1:0] IDX_A_OE  = 5'h02;
  localparam logic [IDX_W-1:0] IDX_D_OUT = 5'h10;
  localparam logic [IDX_W-1:0] IDX_D_IN  = 5'h11;
  localparam logic [IDX_W-1:0] IDX_D_OE  = 5'h12;

  localparam int BIT_ALE   = 6;
  localparam int BIT_CLE   = 5;
  localparam int BIT_CE    = 4;
  localparam int BIT_RDY   = 7;
  localparam int BIT_SCLK  = 1;
  localparam int BIT_SDI   = 4;
  localparam int BIT_SDO   = 4;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_tap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output logic [IDX_W-1:0]  idx,
  output logic              acc_ok
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_WORDS);

  always_comb begin
    idx    = addr[ADDR_W-1:2];
    acc_ok = (be == {BE_W{1'b1}}) && ({1'b0, idx} < LIMIT);
  end
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_tap_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]   words
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    if (g == int'(IDX_A_IN) || g == int'(IDX_D_IN)) begin : g_view
      assign words[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n)                                   words[g] <= '0;
        else if (wr_en && wr_idx == IDX_W'(g))        words[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/gpio_edge_notify.sv
module gpio_edge_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic old_clk,
  input  logic new_clk,
  input  logic new_data,
  output logic evt,
  output logic level,
  output logic data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt   <= 1'b0;
      level <= 1'b0;
      data  <= 1'b0;
    end else begin
      evt <= hit && (old_clk != new_clk);
      if (hit && (old_clk != new_clk)) begin
        level <= new_clk;
        data  <= new_data;
      end
    end
  end
endmodule

// File: rtl/gpio_tap_ctrl.sv
module gpio_tap_ctrl
  import gpio_tap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              flash_rdy,
  input  logic              sensor_sdo,
  output logic              flash_ale,
  output logic              flash_cle,
  output logic              flash_ce,
  output logic              sclk_evt,
  output logic              sclk_level,
  output logic              sclk_sdi
);
  logic [IDX_W-1:0]                 idx;
  logic                             acc_ok;
  logic                             wr_en;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0]                view;

  gpio_bus_decode u_dec (
    .addr   (bus_addr),
    .be     (bus_be),
    .idx    (idx),
    .acc_ok (acc_ok)
  );

  assign wr_en = bus_wr && acc_ok;

  gpio_reg_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wr_data (bus_wdata),
    .words   (words)
  );

  gpio_edge_notify u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (wr_en && idx == IDX_D_OUT),
    .old_clk  (words[IDX_D_OUT][BIT_SCLK]),
    .new_clk  (bus_wdata[BIT_SCLK]),
    .new_data (bus_wdata[BIT_SDI]),
    .evt      (sclk_evt),
    .level    (sclk_level),
    .data     (sclk_sdi)
  );

  assign flash_ale = words[IDX_A_OUT][BIT_ALE];
  assign flash_cle = words[IDX_A_OUT][BIT_CLE];
  assign flash_ce  = words[IDX_A_OUT][BIT_CE];

  always_comb begin
    view = '0;
    if (acc_ok) begin
      case (idx)
        IDX_A_IN: begin
          view = words[IDX_A_OUT] & words[IDX_A_OE];
          view[BIT_RDY] = view[BIT_RDY] | flash_rdy;
        end
        IDX_D_IN: begin
          view = words[IDX_D_OUT] & words[IDX_D_OE];
          view[BIT_SDO] = view[BIT_SDO] | sensor_sdo;
        end
        default: view = words[idx];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? view : '0;
    end
  end
endmodule

// File: rtl/gpio_tap_ctrl_chk.sv
module gpio_tap_ctrl_chk
  import gpio_tap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BE_W-1:0]   bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              flash_ale,
  input logic              flash_cle,
  input logic              flash_ce,
  input logic              sclk_evt,
  input logic              sclk_level,
  input logic              sclk_sdi
);
  // R2: valid flag follows a read strobe by one cycle
  a_r2_rvalid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd));

  // R7: partial byte enable reads return zero
  a_r7_partial_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(bus_be) != 4'hF) |-> bus_rdata == '0);

  // R8: out-of-window reads return zero
  a_r8_window_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(bus_addr[ADDR_W-1:2]) >= IDX_W'(NUM_WORDS)) |-> bus_rdata == '0);

  // R5: strobes move only after a full write to port A output word
  a_r5_strobes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr && bus_be == 4'hF && bus_addr[ADDR_W-1:2] == IDX_A_OUT)
    |-> $stable({flash_ale, flash_cle, flash_ce}));

  // R6: an event comes only from a full write to port D output word
  a_r6_evt_source: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_evt |-> $past(bus_wr && bus_be == 4'hF && bus_addr[ADDR_W-1:2] == IDX_D_OUT));

  // R6: event carries the written clock level and data bit
  a_r6_evt_payload: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_evt |-> (sclk_level == $past(bus_wdata[BIT_SCLK]) && sclk_sdi == $past(bus_wdata[BIT_SDI])));
endmodule

bind gpio_tap_ctrl gpio_tap_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .flash_ale  (flash_ale),
  .flash_cle  (flash_cle),
  .flash_ce   (flash_ce),
  .sclk_evt   (sclk_evt),
  .sclk_level (sclk_level),
  .sclk_sdi   (sclk_sdi)
);

// File: tb/test_gpio_tap_ctrl.sv
module test_gpio_tap_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        flash_rdy = 1'b0, sensor_sdo = 1'b0;
  logic        flash_ale, flash_cle, flash_ce;
  logic        sclk_evt, sclk_level, sclk_sdi;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_tap_ctrl i_gpio_tap_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .flash_rdy(flash_rdy), .sensor_sdo(sensor_sdo),
    .flash_ale(flash_ale), .flash_cle(flash_cle), .flash_ce(flash_ce),
    .sclk_evt(sclk_evt), .sclk_level(sclk_level), .sclk_sdi(sclk_sdi)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = 4'h0;
    check("R2 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 strobes", {29'b0, flash_ale, flash_cle, flash_ce}, 0);
    check("R1 evt", {31'b0, sclk_evt}, 0);
    check("R1 rvalid", {31'b0, bus_rvalid}, 0);
    rd(7'h0C, d); check("R1 word3", d, 0);
  endtask

  task automatic t_storage();
    logic [31:0] d;
    wr(7'h0C, 32'hDEADBEEF); rd(7'h0C, d); check("R2 word3", d, 32'hDEADBEEF);
    wr(7'h58, 32'h12345678); rd(7'h58, d); check("R2 word22", d, 32'h12345678);
    @(negedge clk);
    check("R2 rvalid drop", {31'b0, bus_rvalid}, 0);
  endtask

  task automatic t_port_a();
    logic [31:0] d;
    wr(7'h00, 32'h0000_00F3);
    check("R5 strobes", {29'b0, flash_ale, flash_cle, flash_ce}, 3'b111);
    wr(7'h08, 32'h0000_0031);
    flash_rdy = 1'b0; rd(7'h04, d); check("R3 view rdy0", d, 32'h31);
    flash_rdy = 1'b1; rd(7'h04, d); check("R3 view rdy1", d, 32'hB1);
    flash_rdy = 1'b0;
    wr(7'h00, 32'h0000_0020);
    check("R5 cle only", {29'b0, flash_ale, flash_cle, flash_ce}, 3'b010);
    rd(7'h00, d); check("R2 porta out", d, 32'h20);
  endtask

  task automatic t_port_d();
    logic [31:0] d;
    wr(7'h48, 32'h0000_000F);
    wr(7'h40, 32'h0000_0007);
    sensor_sdo = 1'b0; rd(7'h44, d); check("R4 view sdo0", d, 32'h7);
    sensor_sdo = 1'b1; rd(7'h44, d); check("R4 view sdo1", d, 32'h17);
    sensor_sdo = 1'b0;
  endtask

  task automatic t_sclk();
    wr(7'h40, 32'h0);  // clock bit falls from 1 (set by 0x7)
    wr(7'h40, 32'h0000_0002);
    check("R6 rise evt", {29'b0, sclk_evt, sclk_level, sclk_sdi}, 3'b110);
    @(negedge clk);
    check("R6 single cycle", {31'b0, sclk_evt}, 0);
    wr(7'h40, 32'h0000_0012);
    check("R6 no evt same level", {31'b0, sclk_evt}, 0);
    wr(7'h40, 32'h0000_0010);
    check("R6 fall evt", {29'b0, sclk_evt, sclk_level, sclk_sdi}, 3'b101);
  endtask

  task automatic t_partial();
    logic [31:0] d;
    wr(7'h0C, 32'hFFFF_0000, 4'h3);
    rd(7'h0C, d); check("R7 partial write ignored", d, 32'hDEADBEEF);
    rd(7'h0C, d, 4'h7); check("R7 partial read zero", d, 0);
    wr(7'h00, 32'h0000_0070, 4'hE);
    check("R7 strobes unchanged", {29'b0, flash_ale, flash_cle, flash_ce}, 3'b010);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(7'h5C, 32'hCAFEF00D);
    rd(7'h5C, d); check("R8 out of window read", d, 0);
    rd(7'h7C, d); check("R8 top index read", d, 0);
    rd(7'h58, d); check("R8 last word intact", d, 32'h12345678);
  endtask

  task automatic t_view_write();
    logic [31:0] d;
    wr(7'h04, 32'hFFFF_FFFF);
    wr(7'h44, 32'hFFFF_FFFF);
    rd(7'h04, d); check("R9 port A view", d, 32'h20 & 32'h31);
    rd(7'h44, d); check("R9 port D view", d, 32'h10 & 32'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_storage();
    t_port_a();
    t_port_d();
    t_sclk();
    t_partial();
    t_window();
    t_view_write();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule